// File: doc/BRIEF.md
# Event Fragment Synchronization Checker

This block sits at the input of a readout link receiver, just after the deserializer. Each cycle it can take one 32-bit word, and it splits the stream into event fragments. Fragments are bounded by separator words, and each one opens with a header that carries a bunch identifier and an event identifier. The checker compares those identifiers with the next entry of a local reference queue, which the trigger side fills. Only the low `ID_W` bits of each identifier are compared, with `ID_W` set between 4 and 12. Inside a fragment, every data word must carry the two low bits of the header's bunch identifier in its top two bits.

Any fault sends the checker into a hunt phase: an identifier mismatch, an empty reference queue, a bad data tag, or a word that the deserializer has marked as corrupt. In the hunt phase it throws words away. One clean separator word brings it back into alignment, and it then waits for the next header.

Saturating counters track words, good events, identifier mismatches, queue underflows and link errors. Sticky flags record each error class. A small register port reads both, and any write on that port clears them.

Top module: `frag_sync_checker`

## Requirements
- R1: After reset the phase is hunt, all counters read zero, all sticky flags are clear and the reference queue is empty.
- R2: In the hunt phase, every word other than a clean separator (`SEP_WORD`) is discarded. A clean separator moves the phase to expect-header.
- R3: In expect-header, a non-separator word is a header, with the bunch ID in bits [ID_W-1:0] and the event ID in bits [16+ID_W-1:16]. If both equal the head of the reference queue, that entry is popped, the event counter increments and the phase becomes in-fragment. Header bits above ID_W in each field are ignored.
- R4: If a header's IDs differ from the queue head, the mismatch counter increments and sticky flag bit 0 is set. The entry is still popped, and the phase becomes hunt.
- R5: A header that arrives while the reference queue is empty increments the underflow counter and sets sticky flag bit 1. Nothing is popped, and the phase becomes hunt.
- R6: In-fragment, a data word whose bits [31:30] differ from the header bunch ID bits [1:0] increments the link-error counter, sets sticky flag bit 2 and moves the phase to hunt.
- R7: A word flagged by `link_err` in any phase counts as a link error, sets flag bit 2 and forces hunt. A flagged separator does not realign the checker.
- R8: In-fragment, a separator ends the fragment and moves the phase to expect-header. In expect-header, further separators are idle words that change nothing.
- R9: The word counter counts every cycle with `link_valid` high, whatever the phase. Cycles with `link_valid` low change no state and no counter.
- R10: Every counter stops at its maximum value (2^CNT_W-1) instead of wrapping.
- R11: A register write clears all counters and sticky flags. It wins over an increment in the same cycle, and it leaves the reference queue untouched.
- R12: The reference queue is first-in first-out with `REF_DEPTH` entries. A push while the queue is full is dropped.
- R13: Register map: address 0 is status, with bits [2:0] the sticky flags and bits [4:3] the phase (0 hunt, 1 expect-header, 2 in-fragment). Addresses 1 to 5 are the word, event, mismatch, underflow and link-error counters. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_valid | input | 1 | A word is present this cycle |
| link_word | input | 32 | Received word |
| link_err | input | 1 | Deserializer marks the word as corrupt |
| ref_push | input | 1 | Push one reference entry |
| ref_bid | input | ID_W | Reference bunch ID |
| ref_evid | input | ID_W | Reference event ID |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write, clears counters and flags |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A stimulus table drives a stream that starts misaligned and then contains several kinds of fragment: a clean one, one with extra idle separators, one whose header has junk above the compared width, one with a bad data tag, one with a wrong event ID, and one that arrives with the queue empty. After each word the bench checks the phase and the event count, which separates a correct realignment from a premature or missed one, and separates a match from a mismatch. Directed sequences then cover the following:
- a flagged separator, which must not realign;
- an over-full queue, whose fifth header must underflow, which also proves the order of the queue;
- counter saturation;
- a clear that arrives in the same cycle as a counted word.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_HDR  = 2'd1,
    PH_FRAG = 2'd2
  } phase_e;

  localparam int NUM_CNT  = 5;
  localparam int CNT_WORD = 0;
  localparam int CNT_EVT  = 1;
  localparam int CNT_MM   = 2;
  localparam int CNT_UF   = 3;
  localparam int CNT_LNK  = 4;
endpackage

// File: rtl/fsc_ref_fifo.sv
module fsc_ref_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          full, do_wr, do_rd;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign dout  = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_wr) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (do_rd) rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_q] <= din;
  end

  // R12: a push into a full queue leaves the occupancy unchanged
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == (AW+1)'(DEPTH)));

  // R5: the tracker never pops an empty queue
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/fsc_sat_counter.sv
module fsc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr) q_d = '0;
    else if (inc && (q != '1)) q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R10: a full counter stays full until cleared
  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((q == '1) && !clr) |=> (q == '1));

  // R11: clear takes priority and empties the counter
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/fsc_frame_tracker.sv
module fsc_frame_tracker
  import fsc_pkg::*;
#(
  parameter int          ID_W     = 12,
  parameter logic [31:0] SEP_WORD = 32'hB5C3_A5E7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_word,
  input  logic            in_err,
  input  logic            ref_empty,
  input  logic [ID_W-1:0] ref_bid,
  input  logic [ID_W-1:0] ref_evid,
  output logic            ref_pop,
  output phase_e          phase,
  output logic            hit_evt,
  output logic            hit_mm,
  output logic            hit_uf,
  output logic            hit_lnk
);
  phase_e     phase_d;
  logic [1:0] tag_q, tag_d;
  logic       is_sep, ids_ok;

  assign is_sep = (in_word == SEP_WORD);
  assign ids_ok = (in_word[ID_W-1:0] == ref_bid) &&
                  (in_word[16+ID_W-1:16] == ref_evid);

  always_comb begin
    phase_d = phase;
    tag_d   = tag_q;
    ref_pop = 1'b0;
    hit_evt = 1'b0;
    hit_mm  = 1'b0;
    hit_uf  = 1'b0;
    hit_lnk = 1'b0;
    if (in_valid) begin
      if (in_err) begin
        hit_lnk = 1'b1;
        phase_d = PH_HUNT;
      end else begin
        unique case (phase)
          PH_HUNT: if (is_sep) phase_d = PH_HDR;
          PH_HDR: begin
            if (!is_sep) begin
              if (ref_empty) begin
                hit_uf  = 1'b1;
                phase_d = PH_HUNT;
              end else begin
                ref_pop = 1'b1;
                if (ids_ok) begin
                  hit_evt = 1'b1;
                  tag_d   = in_word[1:0];
                  phase_d = PH_FRAG;
                end else begin
                  hit_mm  = 1'b1;
                  phase_d = PH_HUNT;
                end
              end
            end
          end
          PH_FRAG: begin
            if (is_sep) phase_d = PH_HDR;
            else if (in_word[31:30] != tag_q) begin
              hit_lnk = 1'b1;
              phase_d = PH_HUNT;
            end
          end
          default: phase_d = PH_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HUNT;
      tag_q <= '0;
    end else begin
      phase <= phase_d;
      tag_q <= tag_d;
    end
  end

  // R2: outside a clean separator, the hunt phase is kept
  assert_hunt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HUNT && in_valid && (in_err || !is_sep)) |=> (phase == PH_HUNT));

  // R7: a flagged word always ends in hunt
  assert_err_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_err) |=> (phase == PH_HUNT));

  // R9: an empty cycle leaves the phase alone
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase));

  // R4, R5, R6: at most one error class per word
  assert_single_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_mm, hit_uf, hit_lnk}));
endmodule

// File: rtl/frag_sync_checker.sv
module frag_sync_checker
  import fsc_pkg::*;
#(
  parameter int          ID_W      = 12,
  parameter int          REF_DEPTH = 16,
  parameter int          CNT_W     = 32,
  parameter logic [31:0] SEP_WORD  = 32'hB5C3_A5E7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_valid,
  input  logic [31:0]     link_word,
  input  logic            link_err,
  input  logic            ref_push,
  input  logic [ID_W-1:0] ref_bid,
  input  logic [ID_W-1:0] ref_evid,
  input  logic [2:0]      reg_addr,
  input  logic            reg_we,
  output logic [31:0]     reg_rdata
);
  localparam int REF_W = 2 * ID_W;

  logic [REF_W-1:0] ref_head;
  logic             ref_empty, ref_pop;
  phase_e           phase;
  logic             hit_evt, hit_mm, hit_uf, hit_lnk;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_q [NUM_CNT];
  logic [2:0]       flags_q, flags_d;

  fsc_ref_fifo #(.W(REF_W), .DEPTH(REF_DEPTH)) u_ref (
    .clk(clk), .rst_n(rst_n),
    .push(ref_push), .din({ref_bid, ref_evid}),
    .pop(ref_pop), .dout(ref_head), .empty(ref_empty)
  );

  fsc_frame_tracker #(.ID_W(ID_W), .SEP_WORD(SEP_WORD)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(link_valid), .in_word(link_word), .in_err(link_err),
    .ref_empty(ref_empty),
    .ref_bid(ref_head[REF_W-1:ID_W]), .ref_evid(ref_head[ID_W-1:0]),
    .ref_pop(ref_pop), .phase(phase),
    .hit_evt(hit_evt), .hit_mm(hit_mm), .hit_uf(hit_uf), .hit_lnk(hit_lnk)
  );

  always_comb begin
    cnt_inc           = '0;
    cnt_inc[CNT_WORD] = link_valid;
    cnt_inc[CNT_EVT]  = hit_evt;
    cnt_inc[CNT_MM]   = hit_mm;
    cnt_inc[CNT_UF]   = hit_uf;
    cnt_inc[CNT_LNK]  = hit_lnk;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    fsc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(reg_we), .inc(cnt_inc[i]), .q(cnt_q[i])
    );
  end

  always_comb begin
    if (reg_we) flags_d = '0;
    else        flags_d = flags_q | {hit_lnk, hit_uf, hit_mm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      3'd0: reg_rdata[4:0]       = {phase, flags_q};
      3'd1: reg_rdata[CNT_W-1:0] = cnt_q[CNT_WORD];
      3'd2: reg_rdata[CNT_W-1:0] = cnt_q[CNT_EVT];
      3'd3: reg_rdata[CNT_W-1:0] = cnt_q[CNT_MM];
      3'd4: reg_rdata[CNT_W-1:0] = cnt_q[CNT_UF];
      3'd5: reg_rdata[CNT_W-1:0] = cnt_q[CNT_LNK];
      default: reg_rdata = '0;
    endcase
  end

  // R4: the mismatch flag stays set until a register write
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[0] && !reg_we) |=> flags_q[0]);

  // R11: a register write empties every flag
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (flags_q == '0));

  // R3: a matched header always lands in-fragment
  assert_match_frag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (phase == PH_FRAG));
endmodule

// File: tb/tb_frag_sync_checker.sv
module tb_frag_sync_checker;
  localparam int          CLK_PERIOD = 10;
  localparam int          ID_W       = 8;
  localparam int          DEPTH      = 4;
  localparam int          CW         = 8;
  localparam logic [31:0] SEP        = 32'hB5C3_A5E7;

  logic clk, rst_n, link_valid, link_err, ref_push, reg_we;
  logic [31:0] link_word, reg_rdata;
  logic [ID_W-1:0] ref_bid, ref_evid;
  logic [2:0] reg_addr;
  int checks, errors;

  frag_sync_checker #(.ID_W(ID_W), .REF_DEPTH(DEPTH), .CNT_W(CW), .SEP_WORD(SEP)) dut (
    .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .link_word(link_word),
    .link_err(link_err), .ref_push(ref_push), .ref_bid(ref_bid), .ref_evid(ref_evid),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {err, word, expected phase, expected event count}
  localparam logic [42:0] VEC [16] = '{
    {1'b0, 32'h1234_5678, 2'd0, 8'd0},  // R2 junk in hunt
    {1'b0, 32'h0001_0012, 2'd0, 8'd0},  // R2 header-like word in hunt
    {1'b0, SEP,           2'd1, 8'd0},  // R2 realign
    {1'b0, SEP,           2'd1, 8'd0},  // R8 idle separator
    {1'b0, 32'h0001_0012, 2'd2, 8'd1},  // R3 match
    {1'b0, 32'h8000_0011, 2'd2, 8'd1},  // R6 tag ok
    {1'b0, 32'h8000_0044, 2'd2, 8'd1},
    {1'b0, SEP,           2'd1, 8'd1},  // R8 fragment end
    {1'b0, 32'h0702_0A35, 2'd2, 8'd2},  // R3 high bits ignored
    {1'b0, 32'h4000_0022, 2'd2, 8'd2},
    {1'b0, 32'hC000_0033, 2'd0, 8'd2},  // R6 bad tag
    {1'b0, 32'h4000_0022, 2'd0, 8'd2},
    {1'b0, SEP,           2'd1, 8'd2},
    {1'b0, 32'h0009_0040, 2'd0, 8'd2},  // R4 event ID mismatch
    {1'b0, SEP,           2'd1, 8'd2},
    {1'b0, 32'h0004_0050, 2'd0, 8'd2}   // R5 empty queue
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic send(input logic [31:0] w, input logic e);
    @(negedge clk);
    link_valid = 1'b1; link_word = w; link_err = e;
    @(negedge clk);
    link_valid = 1'b0; link_err = 1'b0;
  endtask

  task automatic push(input logic [ID_W-1:0] b, input logic [ID_W-1:0] ev);
    @(negedge clk);
    ref_push = 1'b1; ref_bid = b; ref_evid = ev;
    @(negedge clk);
    ref_push = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; link_valid = 1'b0; link_word = '0; link_err = 1'b0;
    ref_push = 1'b0; ref_bid = '0; ref_evid = '0; reg_addr = '0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R13 unused address
    for (int a = 0; a < 6; a++) expect_reg("R1 reset register", 3'(a), 32'h0);
    expect_reg("R13 unused address", 3'd7, 32'h0);

    push(8'h12, 8'h01);
    push(8'h35, 8'h02);
    push(8'h40, 8'h03);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      send(VEC[i][41:10], VEC[i][42]);
      rd(3'd0, v);
      check($sformatf("R2/R3/R4/R5/R6/R8 table step %0d phase", i), {30'h0, v[4:3]}, {30'h0, VEC[i][9:8]});
      rd(3'd2, v);
      check($sformatf("R3 table step %0d events", i), v, {24'h0, VEC[i][7:0]});
    end
    expect_reg("R9 word count", 3'd1, 32'd16);
    expect_reg("R4 mismatch count", 3'd3, 32'd1);
    expect_reg("R5 underflow count", 3'd4, 32'd1);
    expect_reg("R6 link error count", 3'd5, 32'd1);
    expect_reg("R13 status flags", 3'd0, 32'h07);

    // R11 clear, R9 idle cycles
    clear();
    expect_reg("R11 cleared status", 3'd0, 32'h0);
    expect_reg("R11 cleared words", 3'd1, 32'h0);
    @(negedge clk);
    link_word = SEP;
    repeat (3) @(negedge clk);
    expect_reg("R9 idle words", 3'd1, 32'h0);
    expect_reg("R9 idle phase", 3'd0, 32'h0);

    // R7 flagged separator
    push(8'h11, 8'h05);
    send(SEP, 1'b0);
    expect_reg("R7 aligned", 3'd0, 32'h08);
    send(SEP, 1'b1);
    expect_reg("R7 flagged separator hunt", 3'd0, 32'h04);
    expect_reg("R7 link error count", 3'd5, 32'd1);
    send(SEP, 1'b0);
    send(32'h0005_0011, 1'b0);
    expect_reg("R7 recovery phase", 3'd0, 32'h14);
    expect_reg("R7 recovery events", 3'd2, 32'd1);

    // R12 overfill and order
    clear();
    for (int k = 1; k <= 5; k++) push(8'(k), 8'(k));
    for (int k = 1; k <= 4; k++) begin
      send(SEP, 1'b0);
      send({8'h0, 8'(k), 8'h0, 8'(k)}, 1'b0);
      expect_reg("R12 ordered match", 3'd0, 32'h10);
    end
    send(SEP, 1'b0);
    send(32'h0005_0005, 1'b0);
    expect_reg("R12 dropped push underflows", 3'd4, 32'd1);
    expect_reg("R12 events", 3'd2, 32'd4);
    expect_reg("R12 no mismatch", 3'd3, 32'd0);

    // R11 clear wins over increment, queue kept
    clear();
    push(8'h21, 8'h06);
    @(negedge clk);
    link_valid = 1'b1; link_word = 32'h0; reg_we = 1'b1;
    @(negedge clk);
    link_valid = 1'b0; reg_we = 1'b0;
    expect_reg("R11 clear beats increment", 3'd1, 32'd0);
    send(SEP, 1'b0);
    send(32'h0006_0021, 1'b0);
    expect_reg("R11 queue kept", 3'd2, 32'd1);

    // R10 saturation
    clear();
    for (int n = 0; n < 260; n++) send(32'h0, 1'b0);
    expect_reg("R10 word saturation", 3'd1, 32'd255);
    expect_reg("R10 link count", 3'd5, 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule